// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block sits between a processor-side window into downstream configuration space and a configuration engine that issues type-0 cycles on the PCI bus. Each request carries a 16-bit offset inside the window, an access width of 1, 2 or 4 bytes, a direction and write data. A mapping register held elsewhere supplies the upper half of a 32-bit intermediate address and a flag that asks for a type-1 cycle.

The translator finds the device from a one-hot select field in that intermediate address. The device number is the position of the lowest set bit. It then packs bus, device, function and register into a standard configuration address with the enable bit set. Type-1 requests are refused. A refused read completes at once with all ones over the access width, and a refused write is dropped. An empty select field is reported as a fault.

Every accepted access also produces a write-back of the host's status word with its two received-abort bits cleared. The result of each request is registered once, so it appears on the cycle after the request.

Top module: `cfgx_translator`

## Requirements
- R1: While `rst` is high, `cfg_valid`, `rej_rd_valid`, `idsel_err` and `sts_we` are low on the following cycle, even if a request is presented.
- R2: The result of a request appears exactly one clock after the cycle in which `req_valid` is high. An accepted request raises `cfg_valid` with `cfg_addr[31]`=1 and with `cfg_write`, `cfg_size` and `cfg_wdata` copied from the request.
- R3: The intermediate address is `{map_window[15:0], req_offset}`. Its bits [31:11] form the select field, and the device number `cfg_addr[15:11]` is the index of the lowest set bit of that field. Offset bit 11 gives device 0, and map bit 0 gives device 5.
- R4: `cfg_addr[10:8]` is offset bits [10:8], `cfg_addr[7:2]` is offset bits [7:2], and `cfg_addr[1:0]` and `cfg_addr[30:24]` are zero.
- R5: `cfg_addr[23:16]` equals the static `bus_num` input.
- R6: When several select bits are set, only the lowest one decides the device.
- R7: With `map_window[16]`=1, a read is refused. `rej_rd_valid` pulses and `rej_rd_data` is 0x000000FF for size 1, 0x0000FFFF for size 2 and 0xFFFFFFFF for size 4 (any other size code reads as 4). No `cfg_valid`, `idsel_err` or `sts_we` is raised.
- R8: With `map_window[16]`=1, a write produces no output pulse at all.
- R9: With `map_window[16]`=0 and an all-zero select field, `idsel_err` pulses for one cycle, and `cfg_valid`, `rej_rd_valid` and `sts_we` stay low.
- R10: Every accepted access raises `sts_we` in the same cycle as `cfg_valid`. `sts_wdata` equals the `host_sts` captured with the request, with bit 13 (received master abort) and bit 12 (received target abort) cleared and all other bits kept.
- R11: A type-1 request with an empty select field is handled as a refusal (R7/R8), not as a fault.
- R12: A cycle without `req_valid` produces no output pulse on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 3 | Access width in bytes (1, 2, 4) |
| req_offset | input | 16 | Offset inside the configuration window |
| req_wdata | input | 32 | Write data |
| map_window | input | 17 | Mapping register: [15:0] upper address half, [16] type-1 request |
| bus_num | input | 8 | Static bus number |
| host_sts | input | 16 | Current host status word |
| cfg_valid | output | 1 | Translated request to the configuration engine |
| cfg_write | output | 1 | Direction of the translated request |
| cfg_size | output | 3 | Width of the translated request |
| cfg_addr | output | 32 | Type-0 configuration address with enable |
| cfg_wdata | output | 32 | Write data of the translated request |
| rej_rd_valid | output | 1 | Refused read completes |
| rej_rd_data | output | 32 | All-ones data over the access width |
| idsel_err | output | 1 | Empty select field fault |
| sts_we | output | 1 | Write enable for the host status word |
| sts_wdata | output | 16 | Host status with received-abort bits cleared |

## Verification
Two checks can both apply to one request. A type-1 refusal and an empty-select fault meet when `map_window[16]` is set and the select field is zero. The bench presents exactly that case and expects only the refusal pulse with all-ones data, and no fault pulse. The status clear also coincides with every accepted translation. The bench judges it in the same sampled cycle as `cfg_valid` and uses host words that have each abort bit set alone, both set, and neither set.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
    localparam int OFFS_W   = 16;
    localparam int HI_W     = 16;
    localparam int MAP_W    = HI_W + 1;
    localparam int ADDR_W   = OFFS_W + HI_W;
    localparam int SEL_LSB  = 11;
    localparam int SEL_W    = ADDR_W - SEL_LSB;
    localparam int DEV_W    = 5;
    localparam int FN_W     = 3;
    localparam int REG_W    = 6;
    localparam int BUS_W    = 8;
    localparam int STS_W    = 16;
    localparam int DATA_W   = 32;
    localparam int SIZE_W   = 3;
    localparam int STS_MA   = 13;
    localparam int STS_TA   = 12;

    typedef struct packed {
        logic             type1;
        logic             sel_empty;
        logic [DEV_W-1:0] dev;
        logic [FN_W-1:0]  fn;
        logic [REG_W-1:0] regno;
    } cfg_fields_t;

    typedef enum logic [1:0] {
        OUT_NONE   = 2'd0,
        OUT_CFG    = 2'd1,
        OUT_REJECT = 2'd2,
        OUT_FAULT  = 2'd3
    } outcome_t;

    // Index of the lowest set bit; scanning downward lets the lowest win.
    function automatic logic [DEV_W-1:0] lowest_set(input logic [SEL_W-1:0] v);
        logic [DEV_W-1:0] idx;
        idx = '0;
        for (int i = SEL_W - 1; i >= 0; i--) begin
            if (v[i]) idx = i[DEV_W-1:0];
        end
        return idx;
    endfunction

    function automatic logic [DATA_W-1:0] ones_for_size(input logic [SIZE_W-1:0] sz);
        case (sz)
            3'd1:    return {{(DATA_W-8){1'b0}}, 8'hFF};
            3'd2:    return {{(DATA_W-16){1'b0}}, 16'hFFFF};
            default: return {DATA_W{1'b1}};
        endcase
    endfunction
endpackage

// File: rtl/cfgx_split.sv
module cfgx_split
    import cfgx_pkg::*;
(
    input  logic [OFFS_W-1:0] offset,
    input  logic [MAP_W-1:0]  map_window,
    output cfg_fields_t       fields
);
    logic [ADDR_W-1:0] inter;
    logic [SEL_W-1:0]  sel;
    logic [1:0]        unused_low;

    assign inter      = {map_window[HI_W-1:0], offset};
    assign sel        = inter[ADDR_W-1:SEL_LSB];
    assign unused_low = inter[1:0];

    always_comb begin
        fields.type1     = map_window[MAP_W-1];
        fields.sel_empty = (sel == '0);
        fields.dev       = lowest_set(sel);
        fields.fn        = inter[SEL_LSB-1 -: FN_W];
        fields.regno     = inter[REG_W+1:2];
    end
endmodule

// File: rtl/cfgx_pack.sv
module cfgx_pack
    import cfgx_pkg::*;
(
    input  cfg_fields_t       fields,
    input  logic [BUS_W-1:0]  bus_num,
    output logic [ADDR_W-1:0] addr
);
    localparam int PAD_W = ADDR_W - 1 - BUS_W - DEV_W - FN_W - REG_W - 2;

    assign addr = {1'b1, {PAD_W{1'b0}}, bus_num, fields.dev,
                   fields.fn, fields.regno, 2'b00};
endmodule

// File: rtl/cfgx_translator.sv
module cfgx_translator
    import cfgx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [OFFS_W-1:0] req_offset,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [MAP_W-1:0]  map_window,
    input  logic [BUS_W-1:0]  bus_num,
    input  logic [STS_W-1:0]  host_sts,
    output logic              cfg_valid,
    output logic              cfg_write,
    output logic [SIZE_W-1:0] cfg_size,
    output logic [ADDR_W-1:0] cfg_addr,
    output logic [DATA_W-1:0] cfg_wdata,
    output logic              rej_rd_valid,
    output logic [DATA_W-1:0] rej_rd_data,
    output logic              idsel_err,
    output logic              sts_we,
    output logic [STS_W-1:0]  sts_wdata
);
    cfg_fields_t       fields;
    logic [ADDR_W-1:0] addr_c;
    outcome_t          outcome_c, outcome_q;
    logic [STS_W-1:0]  sts_c;
    logic [STS_W-1:0]  abort_mask;

    cfgx_split u_split (
        .offset     (req_offset),
        .map_window (map_window),
        .fields     (fields)
    );

    cfgx_pack u_pack (
        .fields  (fields),
        .bus_num (bus_num),
        .addr    (addr_c)
    );

    // Refusal is tested before the empty-select fault.
    always_comb begin
        if (!req_valid)           outcome_c = OUT_NONE;
        else if (fields.type1)    outcome_c = req_write ? OUT_NONE : OUT_REJECT;
        else if (fields.sel_empty) outcome_c = OUT_FAULT;
        else                      outcome_c = OUT_CFG;
    end

    always_comb begin
        abort_mask         = '0;
        abort_mask[STS_MA] = 1'b1;
        abort_mask[STS_TA] = 1'b1;
        sts_c              = host_sts & ~abort_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            outcome_q   <= OUT_NONE;
            cfg_write   <= 1'b0;
            cfg_size    <= '0;
            cfg_addr    <= '0;
            cfg_wdata   <= '0;
            rej_rd_data <= '0;
            sts_wdata   <= '0;
        end else begin
            outcome_q <= outcome_c;
            if (req_valid) begin
                cfg_write   <= req_write;
                cfg_size    <= req_size;
                cfg_addr    <= addr_c;
                cfg_wdata   <= req_wdata;
                rej_rd_data <= ones_for_size(req_size);
                sts_wdata   <= sts_c;
            end
        end
    end

    assign cfg_valid    = (outcome_q == OUT_CFG);
    assign sts_we       = (outcome_q == OUT_CFG);
    assign rej_rd_valid = (outcome_q == OUT_REJECT);
    assign idsel_err    = (outcome_q == OUT_FAULT);

    // R12: idle input cycle leaves every output strobe low
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !cfg_valid && !rej_rd_valid && !idsel_err && !sts_we);

    // R2: translated address always carries the enable bit
    a_r2_enable_set: assert property (@(posedge clk) disable iff (rst)
        cfg_valid |-> cfg_addr[ADDR_W-1]);

    // R4: reserved high bits and byte bits stay zero
    a_r4_zero_fields: assert property (@(posedge clk) disable iff (rst)
        cfg_valid |-> (cfg_addr[1:0] == 2'b00) && (cfg_addr[30:24] == '0));

    // R10: write-back never carries an abort bit
    a_r10_aborts_cleared: assert property (@(posedge clk) disable iff (rst)
        sts_we |-> !sts_wdata[STS_MA] && !sts_wdata[STS_TA]);

    // R8: a refusal completion only ever follows a read
    a_r8_reject_is_read: assert property (@(posedge clk) disable iff (rst)
        rej_rd_valid |-> !$past(req_write));

    // R7: refused read data always has its lowest byte all ones
    a_r7_low_byte_ones: assert property (@(posedge clk) disable iff (rst)
        rej_rd_valid |-> (rej_rd_data[7:0] == 8'hFF));

    // R9: a fault comes only from a type-0 request
    a_r9_fault_type0: assert property (@(posedge clk) disable iff (rst)
        idsel_err |-> !$past(map_window[MAP_W-1]));
endmodule

// File: tb/cfgx_translator_bench.sv
module cfgx_translator_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_size = 3'd4;
    logic [15:0] req_offset = '0;
    logic [31:0] req_wdata = '0;
    logic [16:0] map_window = '0;
    logic [7:0]  bus_num = 8'h3A;
    logic [15:0] host_sts = '0;
    logic        cfg_valid, cfg_write, rej_rd_valid, idsel_err, sts_we;
    logic [2:0]  cfg_size;
    logic [31:0] cfg_addr, cfg_wdata, rej_rd_data;
    logic [15:0] sts_wdata;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cfgx_translator u_cfgx_translator (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_offset(req_offset), .req_wdata(req_wdata),
        .map_window(map_window), .bus_num(bus_num), .host_sts(host_sts),
        .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_size(cfg_size),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .rej_rd_valid(rej_rd_valid), .rej_rd_data(rej_rd_data),
        .idsel_err(idsel_err), .sts_we(sts_we), .sts_wdata(sts_wdata)
    );

    // kind: 0 nothing, 1 translated, 2 refused read, 3 fault
    typedef struct packed {
        logic        wr;
        logic [2:0]  size;
        logic [15:0] offs;
        logic [16:0] map;
        logic [15:0] sts;
        logic [1:0]  kind;
        logic [31:0] exp_data;
        logic [15:0] exp_sts;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 3'd4, 16'h0800, 17'h00000, 16'hFFFF, 2'd1, 32'h803A0000, 16'hCFFF}, // R3 dev0
        '{1'b1, 3'd1, 16'h0534, 17'h00001, 16'h3000, 2'd1, 32'h803A2D34, 16'h0000}, // R3 dev5, R4
        '{1'b0, 3'd2, 16'h1007, 17'h00000, 16'h1234, 2'd1, 32'h803A0804, 16'h0234}, // R4 mask
        '{1'b0, 3'd4, 16'hC000, 17'h08000, 16'h2001, 2'd1, 32'h803A1800, 16'h0001}, // R6
        '{1'b1, 3'd4, 16'h07FC, 17'h08000, 16'h0000, 2'd1, 32'h803AA7FC, 16'h0000}, // R3 dev20
        '{1'b0, 3'd1, 16'h0800, 17'h10001, 16'hFFFF, 2'd2, 32'h000000FF, 16'h0000}, // R7 size1
        '{1'b0, 3'd2, 16'h0800, 17'h10001, 16'hFFFF, 2'd2, 32'h0000FFFF, 16'h0000}, // R7 size2
        '{1'b0, 3'd4, 16'h0800, 17'h10001, 16'hFFFF, 2'd2, 32'hFFFFFFFF, 16'h0000}, // R7 size4
        '{1'b1, 3'd4, 16'h0800, 17'h10001, 16'hFFFF, 2'd0, 32'h00000000, 16'h0000}, // R8
        '{1'b0, 3'd4, 16'h07FF, 17'h00000, 16'hFFFF, 2'd3, 32'h00000000, 16'h0000}, // R9 read
        '{1'b1, 3'd2, 16'h0000, 17'h00000, 16'hFFFF, 2'd3, 32'h00000000, 16'h0000}, // R9 write
        '{1'b0, 3'd4, 16'h0000, 17'h10000, 16'hFFFF, 2'd2, 32'hFFFFFFFF, 16'h0000}  // R11
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_strobes(input string req, input logic [3:0] exp);
        chk(req, {28'd0, cfg_valid, rej_rd_valid, idsel_err, sts_we}, {28'd0, exp});
    endtask

    task automatic issue(input vec_t v, input logic [31:0] wd);
        @(negedge clk);
        req_valid  = 1'b1;
        req_write  = v.wr;
        req_size   = v.size;
        req_offset = v.offs;
        map_window = v.map;
        host_sts   = v.sts;
        req_wdata  = wd;
        @(negedge clk);
        req_valid  = 1'b0;
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: reset holds strobes low even with a request present
        req_valid  = 1'b1;
        map_window = 17'h00001;
        @(negedge clk);
        @(negedge clk);
        chk_strobes("R1 reset with request", 4'b0000);
        req_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        chk_strobes("R12 idle after reset", 4'b0000);

        for (int i = 0; i < NV; i++) begin
            logic [31:0] wd;
            wd = 32'hA5000000 + i;
            issue(TBL[i], wd);
            case (TBL[i].kind)
                2'd1: begin
                    chk($sformatf("R2 strobes v%0d", i), {28'd0, cfg_valid, rej_rd_valid, idsel_err, sts_we}, 32'b1001);
                    chk($sformatf("R3/R4/R5/R6 addr v%0d", i), cfg_addr, TBL[i].exp_data);
                    chk($sformatf("R2 write v%0d", i), {31'd0, cfg_write}, {31'd0, TBL[i].wr});
                    chk($sformatf("R2 size v%0d", i), {29'd0, cfg_size}, {29'd0, TBL[i].size});
                    chk($sformatf("R2 wdata v%0d", i), cfg_wdata, wd);
                    chk($sformatf("R10 sts v%0d", i), {16'd0, sts_wdata}, {16'd0, TBL[i].exp_sts});
                end
                2'd2: begin
                    chk($sformatf("R7/R11 strobes v%0d", i), {28'd0, cfg_valid, rej_rd_valid, idsel_err, sts_we}, 32'b0100);
                    chk($sformatf("R7 data v%0d", i), rej_rd_data, TBL[i].exp_data);
                end
                2'd3: chk($sformatf("R9 strobes v%0d", i), {28'd0, cfg_valid, rej_rd_valid, idsel_err, sts_we}, 32'b0010);
                default: chk($sformatf("R8 strobes v%0d", i), {28'd0, cfg_valid, rej_rd_valid, idsel_err, sts_we}, 32'b0000);
            endcase
            @(negedge clk);
            chk($sformatf("R12 quiet after v%0d", i), {28'd0, cfg_valid, rej_rd_valid, idsel_err, sts_we}, 32'b0000);
        end

        // R5: a different static bus number lands in [23:16]
        bus_num = 8'hC5;
        issue(TBL[0], 32'h0);
        chk("R5 bus field", cfg_addr, 32'h80C50000);

        // R2: back-to-back requests each appear one cycle later
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_size = 3'd4;
        map_window = 17'h00000; req_offset = 16'h2000; host_sts = 16'h0;
        @(negedge clk);
        chk("R2 first of pair dev2", cfg_addr, 32'h80C51000);
        req_offset = 16'h0000; map_window = 17'h10000;
        @(negedge clk);
        req_valid = 1'b0;
        chk_strobes("R2/R11 second of pair refused", 4'b0100);
        chk("R7 second of pair data", rej_rd_data, 32'hFFFFFFFF);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule